// File: doc/BRIEF.md
# Bitmap Sequence Number Allocator

This block hands out sequence numbers to instructions as they enter the machine and takes them back when those instructions commit. It keeps one busy bit for every number in a space of `N` values. The numbers are granted in consecutive order, starting at an internal next pointer that wraps modulo `N`. One request can ask for up to `K` contiguous numbers in a cycle. Each free port can return a number in the same cycle, and returns may come in any order. Commit normally returns numbers oldest first, and the block handles that case with no special logic.

The block always reports how many numbers are free. It raises `stall` when the next `K` numbers after the pointer are not all free. A small health state machine has two named states. In `ST_CLEAN` the bookkeeping is consistent. `ST_FAULT` is entered through the transition *bad_release*, which fires on any release of a number that is not in use. The only way out of `ST_FAULT` is reset; there is no other transition. `err_flag` is high exactly in `ST_FAULT`. `N` must be a power of two.

Top module: `seq_tag_alloc`

## Requirements
- R1: After reset every number is free, `avail_count` equals N, the next pointer is 0 (so `alloc_ids` slot 0 shows 0), `stall` is low and `err_flag` is low.
- R2: `alloc_grant` is high in a cycle exactly when `alloc_cnt` is between 1 and K and all `alloc_cnt` numbers starting at the next pointer are free. Slot i of `alloc_ids` (bits i*W and up, W = log2 N) then holds (next + i) mod N. A number that is in use is never granted again.
- R3: On a grant the next pointer advances by `alloc_cnt` modulo N. When nothing is granted, the pointer holds.
- R4: A refused request leaves the busy state, the pointer and `avail_count` unchanged.
- R5: `avail_count` equals the number of free numbers. Granted numbers leave the count in the next cycle.
- R6: `stall` is high exactly when at least one of the K numbers starting at the next pointer is in use.
- R7: A valid release on either free port of a number in use makes that number free in the next cycle. Releases may come in any order, including oldest first.
- R8: A release of a number not in use sets `err_flag` and leaves the busy state of that number unchanged. `err_flag` stays high until reset.
- R9: A release takes effect one cycle later. A number released in a cycle cannot be granted in that same cycle, but it can be granted in the following one.
- R10: An `alloc_cnt` of 0, or one greater than K, is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_cnt | input | $clog2(K+1) | Numbers requested this cycle (0 = none) |
| alloc_grant | output | 1 | Request accepted this cycle |
| alloc_ids | output | K*W | Candidate numbers next+i, slot i at bits i*W |
| stall | output | 1 | Fewer than K contiguous free numbers at the pointer |
| free_valid | input | K | Per-port release strobe |
| free_ids | input | K*W | Released numbers, port i at bits i*W |
| avail_count | output | $clog2(N+1) | Count of free numbers |
| err_flag | output | 1 | Sticky release-of-unused error (ST_FAULT) |

## Verification
Allocation and release can fall in the same cycle, and the case that matters most is a release of the very number the pointer wants to grant next. The bench fills the whole space until the pointer wraps back onto number 0. It then releases 0 while it requests one number in the same cycle, and it expects a refusal with `stall` still high. In the next cycle it expects a grant of 0. A long mixed sweep combines requests of every size with releases in oldest-first and scattered order. A bench-side model of the busy bits judges every cycle's grant, numbers, stall and count, and it flags any grant of a number that is still live.

// File: rtl/seqalloc_pkg.sv
package seqalloc_pkg;
    typedef enum logic [0:0] {
        ST_CLEAN = 1'b0,
        ST_FAULT = 1'b1
    } health_e;
endpackage

// File: rtl/seqalloc_window.sv
// Looks at the K numbers starting at the pointer: their values and free bits.
module seqalloc_window #(
    parameter int N = 16,
    parameter int K = 2,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0]   busy,
    input  logic [W-1:0]   base,
    output logic [K-1:0]   win_free,
    output logic [K*W-1:0] win_ids
);
    for (genvar i = 0; i < K; i++) begin : g_slot
        localparam logic [W-1:0] OFFS = W'(i);
        logic [W-1:0] slot_id;
        assign slot_id             = base + OFFS;   // wraps modulo N (power of two)
        assign win_ids[i*W +: W]   = slot_id;
        assign win_free[i]         = ~busy[slot_id];
    end
endmodule

// File: rtl/seqalloc_decode.sv
// Turns up to P (valid, number) pairs into a one-hot-per-pair mask.
module seqalloc_decode #(
    parameter int N = 16,
    parameter int P = 2,
    parameter int W = $clog2(N)
) (
    input  logic [P-1:0]   en,
    input  logic [P*W-1:0] ids,
    output logic [N-1:0]   mask
);
    always_comb begin
        mask = '0;
        for (int p = 0; p < P; p++) begin
            if (en[p]) mask[ids[p*W +: W]] = 1'b1;
        end
    end
endmodule

// File: rtl/seqalloc_count.sv
// Population count of the free bits.
module seqalloc_count #(
    parameter int N  = 16,
    parameter int AW = $clog2(N+1)
) (
    input  logic [N-1:0]  free_map,
    output logic [AW-1:0] total
);
    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++) begin
            total = total + AW'(free_map[i]);
        end
    end
endmodule

// File: rtl/seq_tag_alloc.sv
module seq_tag_alloc
    import seqalloc_pkg::*;
#(
    parameter int N = 16,
    parameter int K = 2,
    localparam int W  = $clog2(N),
    localparam int CW = $clog2(K+1),
    localparam int AW = $clog2(N+1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   alloc_cnt,
    output logic            alloc_grant,
    output logic [K*W-1:0]  alloc_ids,
    output logic            stall,
    input  logic [K-1:0]    free_valid,
    input  logic [K*W-1:0]  free_ids,
    output logic [AW-1:0]   avail_count,
    output logic            err_flag
);
    logic [N-1:0] busy_q, busy_d;
    logic [W-1:0] next_q, next_d;
    health_e      state_q, state_d;

    logic [K-1:0] win_free;
    logic [K-1:0] set_en;
    logic [K-1:0] rel_ok;
    logic [N-1:0] set_mask, clr_mask;
    logic         bad_release;
    logic         window_ok;

    seqalloc_window #(.N(N), .K(K), .W(W)) u_window (
        .busy     (busy_q),
        .base     (next_q),
        .win_free (win_free),
        .win_ids  (alloc_ids)
    );

    seqalloc_count #(.N(N), .AW(AW)) u_count (
        .free_map (~busy_q),
        .total    (avail_count)
    );

    // Grant: every requested slot in the window is free, count in 1..K.
    always_comb begin
        window_ok = 1'b1;
        for (int i = 0; i < K; i++) begin
            if (CW'(i) < alloc_cnt && !win_free[i]) window_ok = 1'b0;
        end
        alloc_grant = window_ok && (alloc_cnt != '0) && (alloc_cnt <= CW'(K));
        for (int i = 0; i < K; i++) begin
            set_en[i] = alloc_grant && (CW'(i) < alloc_cnt);
        end
    end

    // Releases: only numbers currently in use are cleared; others are errors.
    always_comb begin
        bad_release = 1'b0;
        for (int p = 0; p < K; p++) begin
            rel_ok[p] = free_valid[p] && busy_q[free_ids[p*W +: W]];
            if (free_valid[p] && !busy_q[free_ids[p*W +: W]]) bad_release = 1'b1;
        end
    end

    seqalloc_decode #(.N(N), .P(K), .W(W)) u_set (
        .en   (set_en),
        .ids  (alloc_ids),
        .mask (set_mask)
    );

    seqalloc_decode #(.N(N), .P(K), .W(W)) u_clr (
        .en   (rel_ok),
        .ids  (free_ids),
        .mask (clr_mask)
    );

    assign busy_d = (busy_q | set_mask) & ~clr_mask;
    assign next_d = alloc_grant ? next_q + W'(alloc_cnt) : next_q;

    // Health state machine: next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN: if (bad_release) state_d = ST_FAULT;   // bad_release
            ST_FAULT: state_d = ST_FAULT;                    // held until reset
            default:  state_d = ST_FAULT;
        endcase
    end

    // State register together with bitmap and pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAN;
            busy_q  <= '0;
            next_q  <= '0;
        end else begin
            state_q <= state_d;
            busy_q  <= busy_d;
            next_q  <= next_d;
        end
    end

    // Outputs.
    always_comb begin
        err_flag = (state_q == ST_FAULT);
        stall    = ~&win_free;
    end

    // ---------------- assertions ----------------
    a_r2_grant_is_free: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |-> !busy_q[alloc_ids[W-1:0]]);

    a_r3_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |=> next_q == $past(next_q + W'(alloc_cnt)));

    a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_grant |=> $stable(next_q));

    a_r5_count_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_grant && free_valid == '0) |=>
            avail_count == $past(avail_count) - $past(AW'(alloc_cnt)));

    a_r6_stall_blocks_full: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && alloc_cnt == CW'(K)) |-> !alloc_grant);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    a_r10_bad_count: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_cnt == '0 || alloc_cnt > CW'(K)) |-> !alloc_grant);
endmodule

// File: tb/sim_seq_tag_alloc.sv
`timescale 1ns/1ps
module sim_seq_tag_alloc;
    localparam int N  = 16;
    localparam int K  = 2;
    localparam int W  = $clog2(N);
    localparam int CW = $clog2(K+1);
    localparam int AW = $clog2(N+1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CW-1:0]   alloc_cnt = '0;
    logic            alloc_grant;
    logic [K*W-1:0]  alloc_ids;
    logic            stall;
    logic [K-1:0]    free_valid = '0;
    logic [K*W-1:0]  free_ids = '0;
    logic [AW-1:0]   avail_count;
    logic            err_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit [N-1:0] mbusy;
    int         mnext;
    bit         merr;
    int unsigned lfsr = 32'h1234_5678;

    always #5 clk = ~clk;

    seq_tag_alloc #(.N(N), .K(K)) u0 (
        .clk, .rst_n, .alloc_cnt, .alloc_grant, .alloc_ids, .stall,
        .free_valid, .free_ids, .avail_count, .err_flag
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_avail();
        int c = 0;
        for (int i = 0; i < N; i++) if (!mbusy[i]) c++;
        return c;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; alloc_cnt = '0; free_valid = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mbusy = '0; mnext = 0; merr = 0;
    endtask

    // One cycle: drive at negedge, judge outputs, update model at posedge.
    task automatic cyc(input int cnt, input bit v0, input int f0, input bit v1, input int f1);
        bit exp_g;
        bit exp_stall;
        @(negedge clk);
        alloc_cnt  = CW'(cnt);
        free_valid = {v1, v0};
        free_ids   = {W'(f1), W'(f0)};
        #1;
        exp_g = (cnt >= 1 && cnt <= K);
        for (int i = 0; i < K; i++)
            if (i < cnt && mbusy[(mnext+i)%N]) exp_g = 0;
        exp_stall = 0;
        for (int i = 0; i < K; i++) if (mbusy[(mnext+i)%N]) exp_stall = 1;
        check(alloc_grant == exp_g, (cnt == 0 || cnt > K) ? "R10 grant" : "R2 grant",
              int'(alloc_grant), int'(exp_g));
        for (int i = 0; i < K; i++)
            check(int'(alloc_ids[i*W +: W]) == (mnext+i)%N, "R3 ids/pointer",
                  int'(alloc_ids[i*W +: W]), (mnext+i)%N);
        if (alloc_grant)
            for (int i = 0; i < cnt && i < K; i++)
                check(!mbusy[alloc_ids[i*W +: W]], "R2 live number granted twice",
                      int'(alloc_ids[i*W +: W]), -1);
        check(stall == exp_stall, "R6 stall", int'(stall), int'(exp_stall));
        check(int'(avail_count) == model_avail(), "R5 avail_count",
              int'(avail_count), model_avail());
        check(err_flag == merr, "R8 err_flag", int'(err_flag), int'(merr));
        @(posedge clk);
        begin
            bit [N-1:0] nb = mbusy;
            if (v0) begin if (mbusy[f0]) nb[f0] = 0; else merr = 1; end
            if (v1) begin if (mbusy[f1]) nb[f1] = 0; else merr = 1; end
            if (exp_g) begin
                for (int i = 0; i < cnt; i++) nb[(mnext+i)%N] = 1;
                mnext = (mnext + cnt) % N;
            end
            mbusy = nb;
        end
    endtask

    function automatic int rnd();
        lfsr = lfsr * 1103515245 + 12345;
        return int'(lfsr >> 16);
    endfunction

    function automatic int pick_busy(input int start, input int skip);
        for (int i = 0; i < N; i++) begin
            int id = (start + i) % N;
            if (mbusy[id] && id != skip) return id;
        end
        return -1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        #1;
        check(int'(avail_count) == N, "R1 avail after reset", int'(avail_count), N);
        check(int'(alloc_ids[W-1:0]) == 0, "R1 pointer after reset", int'(alloc_ids[W-1:0]), 0);
        check(!stall && !err_flag, "R1 stall/err after reset", int'({stall, err_flag}), 0);

        // R2/R5: fill the whole space two at a time, pointer wraps to 0
        for (int i = 0; i < N/K; i++) cyc(2, 0, 0, 0, 0);
        // R4/R6: everything busy, all requests refused
        cyc(1, 0, 0, 0, 0);
        cyc(2, 0, 0, 0, 0);
        // R9: release 0 while asking for it in the same cycle -> refused
        cyc(1, 1, 0, 0, 0);
        check(!stall == 0, "R9 stall after same-cycle release", int'(stall), 1);
        cyc(1, 0, 0, 0, 0);     // R9: granted now
        // R7: oldest-first releases on both ports
        for (int i = 1; i < N-1; i += 2) cyc(0, 1, i, 1, i+1);
        cyc(0, 1, N-1, 0, 0);
        // R7: scattered release order after refilling
        for (int i = 0; i < N; i++) cyc(1, 0, 0, 0, 0);
        for (int i = 0; i < N; i += 2) cyc(0, 1, (i*5+3)%N, 1, (i*5+8)%N);
        // R10: counts 0 and 3 ignored
        cyc(3, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        // R8: release of an unused number, error sticky, bitmap untouched
        cyc(0, 1, 7, 0, 0);
        for (int i = 0; i < 4; i++) cyc(2, 0, 0, 0, 0);
        do_reset();
        cyc(0, 0, 0, 0, 0);     // R1 again after fault

        // Mixed sweep: requests of all sizes, oldest-first and scattered releases
        for (int t = 0; t < 3000; t++) begin
            int c  = rnd() % 4;
            int a  = pick_busy(rnd() % N, -1);
            int b  = pick_busy((mnext + N - (N - model_avail())) % N, a);
            bit va = (a >= 0) && (rnd() % 3 != 0);
            bit vb = (b >= 0) && (rnd() % 2 == 0);
            cyc(c, va, va ? a : 0, vb, vb ? b : 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule